// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block adds in-band flow control to a serial port. On the receive side it looks at every decoded byte. A byte equal to the programmed pause character stops the local transmitter from starting new data bytes. A byte equal to the programmed resume character lets the transmitter start data again. Each of these receptions raises a one-cycle event. When the drop option is set, the flow characters are kept out of the receive FIFO.

On the transmit side the block watches how many bytes the receive FIFO holds. When that count rises above a high level, it asks the serializer to insert a pause character ahead of queued data. When the count falls below a low level, it asks for a resume character. The block uses hysteresis, so each character goes out once per crossing.

Software can also queue a single pause or resume character. The serializer takes an injected character through a request/grant handshake, and it grants only between bytes. Two override inputs, force-run and force-halt, control data transmission directly. A bypass input lets flow characters go out while data is held back.

The register file that drives the configuration inputs normally resets them as follows: resume character 0x11, pause character 0x13, high level 12, low level 0.

Top module: `xonoff_flow_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are inj_req=0, tx_data_en=1, both events 0 and both software pending flags 0.
- R2: With cfg_enable=1, a received byte equal to cfg_off_char pauses data: tx_data_en is 0 from the next cycle on, and evt_off_rcvd pulses for exactly that cycle. A received byte equal to cfg_on_char resumes data and pulses evt_on_rcvd in the same way. If both characters are programmed equal, the byte counts as a pause.
- R3: fifo_wr_en follows rx_valid in the same cycle. The only exception is when cfg_enable=1, cfg_drop_flow=1 and the byte matches either flow character; then fifo_wr_en is 0.
- R4: cfg_force_halt=1 forces tx_data_en=0 in the same cycle. Otherwise cfg_force_run=1 makes data run even while paused. Halt wins over run.
- R5: With cfg_enable=1, when rx_fifo_cnt > cfg_pause_lvl and the last automatic character sent was not a pause, inj_req rises in the same cycle with inj_char = cfg_off_char.
- R6: With cfg_enable=1, after an automatic pause character has been granted, rx_fifo_cnt < cfg_resume_lvl requests cfg_on_char. A level that stays past a threshold produces no second request until the opposite character has been granted.
- R7: A one-cycle pulse on sw_send_on or sw_send_off sets the matching pending flag in the next cycle. The flag stays set until the cycle after its character is granted (inj_grant=1 while inj_req=1), unless a new pulse arrives in the grant cycle.
- R8: When several sources want to send, inj_char comes from the first in this order: software pause, software resume, automatic pause, automatic resume. A grant clears only that source.
- R9: While inj_req=1, tx_data_en=0, so the injected character is taken before the next data byte.
- R10: When data is not running (paused or halted) and cfg_bypass=0, inj_req is 0. With cfg_bypass=1, requests go out anyway.
- R11: With cfg_enable=0, received bytes cause no events, no pause and no dropping. From the next cycle the pause state and the hysteresis state are cleared, and no automatic requests are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Enables flow-character handling and automatic requests |
| cfg_drop_flow | input | 1 | Keeps received flow characters out of the FIFO |
| cfg_force_run | input | 1 | Keeps data running despite a pause |
| cfg_force_halt | input | 1 | Stops data; wins over force-run |
| cfg_bypass | input | 1 | Allows flow characters while data is stopped |
| cfg_on_char | input | DW | Resume character |
| cfg_off_char | input | DW | Pause character |
| cfg_pause_lvl | input | CW | FIFO count above which a pause is requested |
| cfg_resume_lvl | input | CW | FIFO count below which a resume is requested |
| sw_send_on | input | 1 | Pulse: queue one resume character |
| sw_send_off | input | 1 | Pulse: queue one pause character |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | DW | Received byte |
| rx_fifo_cnt | input | CW | Receive FIFO occupancy |
| inj_grant | input | 1 | Serializer takes the injected character |
| fifo_wr_en | output | 1 | Write strobe to the receive FIFO |
| inj_req | output | 1 | Injected character waiting |
| inj_char | output | DW | Character to inject |
| tx_data_en | output | 1 | Serializer may start the next data byte |
| evt_on_rcvd | output | 1 | Resume character received (pulse) |
| evt_off_rcvd | output | 1 | Pause character received (pulse) |
| sw_on_pending | output | 1 | Software resume request outstanding |
| sw_off_pending | output | 1 | Software pause request outstanding |

## Verification
Two functions can act in the same cycle: a received pause character, and the grant of an injected character. A pause that lands in that cycle blocks any request still pending from the next cycle on, unless bypass is set. The bench provokes this in directed steps and in a long random phase, where received flow characters, FIFO levels, software pulses and grants all vary cycle by cycle. A behavioural model, kept only as flags and integers, predicts each output every cycle, and each difference is reported with the requirement being exercised.

// File: rtl/ifc_pkg.sv
// Shared definitions for the in-band flow controller.
// Sources of injected characters. The enum order is the priority order:
// index 0 is served first.
package ifc_pkg;
    localparam int SRC_N = 4;

    typedef enum logic [1:0] {
        SRC_SW_OFF   = 2'd0,
        SRC_SW_ON    = 2'd1,
        SRC_AUTO_OFF = 2'd2,
        SRC_AUTO_ON  = 2'd3
    } src_e;
endpackage

// File: rtl/ifc_rx_watch.sv
// Receive-side watcher.
// Compares each received byte with the two flow characters, keeps the
// "peer asked us to pause" state, raises one-cycle events and gates the
// FIFO write strobe.
// Assumes rx_valid is a single-cycle strobe per byte.
module ifc_rx_watch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          drop,
    input  logic [DW-1:0] on_char,
    input  logic [DW-1:0] off_char,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          fifo_wr_en,
    output logic          peer_paused,
    output logic          evt_on,
    output logic          evt_off
);
    logic hit_off;
    logic hit_on;

    // Match decode; a pause match wins when both characters are the same.
    always_comb begin
        hit_off = enable && rx_valid && (rx_data == off_char);
        hit_on  = enable && rx_valid && (rx_data == on_char) && !hit_off;
    end

    // FIFO write strobe, with flow characters removed when asked.
    assign fifo_wr_en = rx_valid && !(drop && (hit_off || hit_on));

    // Pause state and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peer_paused <= 1'b0;
            evt_on      <= 1'b0;
            evt_off     <= 1'b0;
        end else begin
            evt_off <= hit_off;
            evt_on  <= hit_on;
            if (!enable)      peer_paused <= 1'b0;
            else if (hit_off) peer_paused <= 1'b1;
            else if (hit_on)  peer_paused <= 1'b0;
        end
    end

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_on && evt_off)); // R2
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> rx_valid); // R3
    AST_OFF_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        evt_off |-> peer_paused); // R2
endmodule

// File: rtl/ifc_level_req.sv
// Occupancy-driven request generator with hysteresis.
// It wants a pause character when the FIFO count is above the high level,
// and a resume character when the count is below the low level. A
// one-bit memory of the last automatic character granted makes each
// crossing produce a single request.
module ifc_level_req #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] pause_lvl,
    input  logic [CW-1:0] resume_lvl,
    input  logic          took_off,
    input  logic          took_on,
    output logic          want_off,
    output logic          want_on
);
    logic sent_off;

    // Requests qualified by the hysteresis state.
    always_comb begin
        want_off = enable && (rx_cnt > pause_lvl)  && !sent_off;
        want_on  = enable && (rx_cnt < resume_lvl) &&  sent_off;
    end

    // Remember which automatic character went out last.
    always_ff @(posedge clk) begin
        if (!rst_n)        sent_off <= 1'b0;
        else if (!enable)  sent_off <= 1'b0;
        else if (took_off) sent_off <= 1'b1;
        else if (took_on)  sent_off <= 1'b0;
    end

    AST_HYST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(want_off && want_on)); // R6
    AST_NO_REPEAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (took_off && enable) |=> !want_off); // R6
    AST_NO_REPEAT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (took_on && enable) |=> !want_on); // R6
endmodule

// File: rtl/ifc_inject.sv
// Injection arbiter.
// Holds the software one-shot requests, picks the highest-priority source
// and presents its character to the serializer. On a grant it reports
// which source was served. Assumes the serializer grants only between
// bytes, so an injected character never cuts into a byte on the wire.
module ifc_inject
    import ifc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_on_set,
    input  logic             sw_off_set,
    input  logic             want_off,
    input  logic             want_on,
    input  logic [DW-1:0]    on_char,
    input  logic [DW-1:0]    off_char,
    input  logic             allow,
    input  logic             grant,
    output logic             inj_req,
    output logic [DW-1:0]    inj_char,
    output logic [SRC_N-1:0] took,
    output logic             pend_on,
    output logic             pend_off
);
    logic [SRC_N-1:0] cand;
    logic [SRC_N-1:0] sel;
    logic [DW-1:0]    src_char [SRC_N];

    // Candidate vector in priority order.
    always_comb begin
        cand                   = '0;
        cand[int'(SRC_SW_OFF)]   = pend_off;
        cand[int'(SRC_SW_ON)]    = pend_on;
        cand[int'(SRC_AUTO_OFF)] = want_off;
        cand[int'(SRC_AUTO_ON)]  = want_on;
    end

    // Character carried by each source.
    for (genvar g = 0; g < SRC_N; g++) begin : g_char
        if (g == int'(SRC_SW_OFF) || g == int'(SRC_AUTO_OFF)) begin : g_off
            assign src_char[g] = off_char;
        end else begin : g_on
            assign src_char[g] = on_char;
        end
    end

    // Fixed-priority pick: the lowest index wins.
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (cand[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Character mux driven by the one-hot pick.
    always_comb begin
        inj_char = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (sel[i]) inj_char = src_char[i];
        end
    end

    assign inj_req = allow && (|cand);
    assign took    = sel & {SRC_N{grant && inj_req}};

    // Software one-shot flags: set by a pulse, cleared when granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_on  <= 1'b0;
            pend_off <= 1'b0;
        end else begin
            pend_off <= sw_off_set || (pend_off && !took[int'(SRC_SW_OFF)]);
            pend_on  <= sw_on_set  || (pend_on  && !took[int'(SRC_SW_ON)]);
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(took)); // R8
    AST_PEND_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_off && !took[int'(SRC_SW_OFF)]) |=> pend_off); // R7
    AST_PEND_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_on && !took[int'(SRC_SW_ON)]) |=> pend_on); // R7
    AST_PEND_OFF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (took[int'(SRC_SW_OFF)] && !sw_off_set) |=> !pend_off); // R7
    AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |-> !inj_req); // R10
endmodule

// File: rtl/xonoff_flow_ctrl.sv
// In-band (XON/XOFF) software flow controller, top level.
// Joins the receive watcher, the occupancy request generator and the
// injection arbiter, and works out whether data may be transmitted.
// Assumes the configuration inputs are stable register outputs in the
// clk domain, and that the serializer samples inj_char on inj_grant.
module xonoff_flow_ctrl
    import ifc_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_drop_flow,
    input  logic          cfg_force_run,
    input  logic          cfg_force_halt,
    input  logic          cfg_bypass,
    input  logic [DW-1:0] cfg_on_char,
    input  logic [DW-1:0] cfg_off_char,
    input  logic [CW-1:0] cfg_pause_lvl,
    input  logic [CW-1:0] cfg_resume_lvl,
    input  logic          sw_send_on,
    input  logic          sw_send_off,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic [CW-1:0] rx_fifo_cnt,
    input  logic          inj_grant,
    output logic          fifo_wr_en,
    output logic          inj_req,
    output logic [DW-1:0] inj_char,
    output logic          tx_data_en,
    output logic          evt_on_rcvd,
    output logic          evt_off_rcvd,
    output logic          sw_on_pending,
    output logic          sw_off_pending
);
    logic             peer_paused;
    logic             want_off;
    logic             want_on;
    logic             run_base;
    logic             allow;
    logic [SRC_N-1:0] took;

    ifc_rx_watch #(.DW(DW)) u_rx_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .drop        (cfg_drop_flow),
        .on_char     (cfg_on_char),
        .off_char    (cfg_off_char),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .fifo_wr_en  (fifo_wr_en),
        .peer_paused (peer_paused),
        .evt_on      (evt_on_rcvd),
        .evt_off     (evt_off_rcvd)
    );

    ifc_level_req #(.CW(CW)) u_level_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .rx_cnt     (rx_fifo_cnt),
        .pause_lvl  (cfg_pause_lvl),
        .resume_lvl (cfg_resume_lvl),
        .took_off   (took[int'(SRC_AUTO_OFF)]),
        .took_on    (took[int'(SRC_AUTO_ON)]),
        .want_off   (want_off),
        .want_on    (want_on)
    );

    ifc_inject #(.DW(DW)) u_inject (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_on_set  (sw_send_on),
        .sw_off_set (sw_send_off),
        .want_off   (want_off),
        .want_on    (want_on),
        .on_char    (cfg_on_char),
        .off_char   (cfg_off_char),
        .allow      (allow),
        .grant      (inj_grant),
        .inj_req    (inj_req),
        .inj_char   (inj_char),
        .took       (took),
        .pend_on    (sw_on_pending),
        .pend_off   (sw_off_pending)
    );

    // Data run decision: halt beats run, run beats a received pause.
    always_comb begin
        if (cfg_force_halt)     run_base = 1'b0;
        else if (cfg_force_run) run_base = 1'b1;
        else                    run_base = !peer_paused;
    end

    assign allow      = run_base || cfg_bypass;
    assign tx_data_en = run_base && !inj_req;

    AST_HALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_force_halt |-> !tx_data_en); // R4
    AST_DATA_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req |-> !tx_data_en); // R9
    AST_FORCE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_force_run && !cfg_force_halt && !inj_req) |-> tx_data_en); // R4
    AST_PAUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_off_rcvd) && !cfg_force_run && !cfg_bypass) |-> !inj_req); // R10
endmodule

// File: tb/xonoff_flow_ctrl_bench.sv
// Self-checking bench: a flag-level behavioural model predicts every
// output each cycle, plus directed spot checks.
module xonoff_flow_ctrl_bench;
    localparam int DW = 8;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic en, drop, frun, fhalt, byp;
    logic [DW-1:0] onc, offc, rxd;
    logic [CW-1:0] plvl, rlvl, cnt;
    logic son, soff, rxv, gnt;
    logic wr, req, den, evon, evoff, pon, poff;
    logic [DW-1:0] ich;

    always #5 clk = ~clk;

    xonoff_flow_ctrl #(.DW(DW), .CW(CW)) u_xonoff_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_drop_flow(drop),
        .cfg_force_run(frun), .cfg_force_halt(fhalt), .cfg_bypass(byp),
        .cfg_on_char(onc), .cfg_off_char(offc), .cfg_pause_lvl(plvl),
        .cfg_resume_lvl(rlvl), .sw_send_on(son), .sw_send_off(soff),
        .rx_valid(rxv), .rx_data(rxd), .rx_fifo_cnt(cnt), .inj_grant(gnt),
        .fifo_wr_en(wr), .inj_req(req), .inj_char(ich), .tx_data_en(den),
        .evt_on_rcvd(evon), .evt_off_rcvd(evoff), .sw_on_pending(pon),
        .sw_off_pending(poff)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R1 reset";

    // Model state
    bit m_paused, m_evon, m_evoff, m_sent_off, m_pon, m_poff;
    // Model predictions for the current cycle
    bit e_wr, e_req, e_den, hit_on, hit_off, run;
    int e_src;
    logic [DW-1:0] e_char;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void predict();
        bit wo, won;
        hit_off = en && rxv && (rxd == offc);
        hit_on  = en && rxv && (rxd == onc) && !hit_off;
        e_wr    = rxv && !(drop && (hit_off || hit_on));
        run     = fhalt ? 1'b0 : (frun ? 1'b1 : !m_paused);
        wo      = en && (int'(cnt) > int'(plvl)) && !m_sent_off;
        won     = en && (int'(cnt) < int'(rlvl)) && m_sent_off;
        e_src   = m_poff ? 0 : m_pon ? 1 : wo ? 2 : won ? 3 : -1;
        e_req   = (run || byp) && (e_src >= 0);
        e_char  = (e_src == 0 || e_src == 2) ? offc : onc;
        e_den   = run && !e_req;
    endfunction

    // One clock: compare before the edge, then advance the model.
    task automatic cyc();
        bit taken;
        #1;
        predict();
        chk("fifo_wr_en", wr, e_wr);
        chk("inj_req", req, e_req);
        chk("tx_data_en", den, e_den);
        chk("evt_on_rcvd", evon, m_evon);
        chk("evt_off_rcvd", evoff, m_evoff);
        chk("sw_on_pending", pon, m_pon);
        chk("sw_off_pending", poff, m_poff);
        if (e_req) chk("inj_char", ich, e_char);
        taken = gnt && e_req;
        @(posedge clk);
        if (!rst_n) begin
            {m_paused, m_evon, m_evoff, m_sent_off, m_pon, m_poff} = '0;
        end else begin
            m_evoff = hit_off;
            m_evon  = hit_on;
            if (!en) m_paused = 0;
            else if (hit_off) m_paused = 1;
            else if (hit_on) m_paused = 0;
            if (!en) m_sent_off = 0;
            else if (taken && e_src == 2) m_sent_off = 1;
            else if (taken && e_src == 3) m_sent_off = 0;
            m_poff = soff || (m_poff && !(taken && e_src == 0));
            m_pon  = son  || (m_pon  && !(taken && e_src == 1));
        end
        @(negedge clk);
        rxv = 0; son = 0; soff = 0; gnt = 0;
    endtask

    task automatic rx_byte(input logic [DW-1:0] b);
        rxv = 1; rxd = b; cyc();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running, expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; en = 1; drop = 0; frun = 0; fhalt = 0; byp = 0;
        onc = 8'h11; offc = 8'h13; plvl = 5'd12; rlvl = 5'd0; cnt = 0;
        son = 0; soff = 0; rxv = 0; rxd = 0; gnt = 0;
        @(posedge clk); @(negedge clk);
        tag = "R1 reset";
        idle(3);
        chk("tx_data_en after reset", den, 1'b1);
        chk("inj_req after reset", req, 1'b0);
        rst_n = 1;
        idle(2);

        tag = "R2 pause/resume";
        rx_byte(8'h41);
        rx_byte(8'h13);
        #1 chk("R2 evt_off pulse", evoff, 1'b1);
        chk("R2 paused", den, 1'b0);
        idle(2);
        rx_byte(8'h11);
        #1 chk("R2 resumed", den, 1'b1);
        idle(1);

        tag = "R3 drop";
        drop = 1;
        rxv = 1; rxd = 8'h13; #1 chk("R3 drop xoff", wr, 1'b0); cyc();
        rx_byte(8'h11);
        rx_byte(8'h55);
        en = 0; rxv = 1; rxd = 8'h13; #1 chk("R11 no drop when off", wr, 1'b1);
        tag = "R11 disabled"; cyc();
        idle(2);
        en = 1; drop = 0;

        tag = "R4 force";
        rx_byte(8'h13);
        frun = 1; idle(1);
        #1 chk("R4 force_run", den, 1'b1);
        fhalt = 1; idle(1);
        #1 chk("R4 halt wins", den, 1'b0);
        fhalt = 0; frun = 0;
        rx_byte(8'h11);

        tag = "R5 auto pause";
        cnt = 13;
        #1 chk("R5 req", req, 1'b1);
        chk("R5 char", ich, 8'h13);
        chk("R9 data held", den, 1'b0);
        idle(2);
        gnt = 1; cyc();
        tag = "R6 hysteresis";
        idle(3);
        #1 chk("R6 no repeat", req, 1'b0);
        cnt = 0; rlvl = 2; idle(1);
        #1 chk("R6 resume char", ich, 8'h11);
        gnt = 1; cyc();
        idle(2);
        rlvl = 0;

        tag = "R7 sw one-shot";
        son = 1; cyc();
        idle(3);
        #1 chk("R7 pending held", pon, 1'b1);
        gnt = 1; cyc();
        #1 chk("R7 cleared", pon, 1'b0);

        tag = "R8 priority";
        son = 1; soff = 1; cnt = 20; cyc();
        #1 chk("R8 first sw off", ich, 8'h13);
        for (int i = 0; i < 4; i++) begin gnt = 1; cyc(); end
        cnt = 0; idle(2);

        tag = "R10 blocked";
        rx_byte(8'h13);
        soff = 1; cyc();
        idle(2);
        #1 chk("R10 blocked", req, 1'b0);
        byp = 1; idle(1);
        #1 chk("R10 bypass", req, 1'b1);
        gnt = 1; cyc();
        byp = 0;
        rx_byte(8'h11);
        idle(2);

        tag = "R11 disabled";
        en = 0; cnt = 31;
        rx_byte(8'h13);
        #1 chk("R11 not paused", den, 1'b1);
        idle(2);
        en = 1; cnt = 0;

        tag = "R2 R8 R10 same-cycle random";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            rxv = (r < 4);
            rxd = (r == 0) ? 8'h13 : (r == 1) ? 8'h11 : 8'h41;
            cnt = 5'($urandom_range(0, 31));
            rlvl = 5'($urandom_range(0, 6));
            gnt = ($urandom_range(0, 2) == 0);
            son = ($urandom_range(0, 40) == 0);
            soff = ($urandom_range(0, 40) == 0);
            drop = ($urandom_range(0, 1) == 0);
            byp = ($urandom_range(0, 5) == 0);
            frun = ($urandom_range(0, 9) == 0);
            fhalt = ($urandom_range(0, 11) == 0);
            if (i % 500 == 0) en = ~en;
            if (i == 2000) onc = 8'h13;
            cyc();
        end
        done = 1'b1;
        finish_run();
    end
endmodule